// File: doc/BRIEF.md
# Sampling Column Phase Sequencer

This block drives the switches of a switched-capacitor delay-and-add array. The array has several storage columns, each with nine channel rows. Once per conversion period the sequencer launches a sampling burst into the next column in rotation. A burst closes the nine channel switches of that column one after another, and consecutive switches are separated by a programmable step interval. A column whose burst has finished waits for its turn to be read. At a period boundary the sequencer pulses the integrator clear and then gives that column its readout enable for one cycle. A converter start strobe is issued every period.

Bursts of different columns overlap in time. Each column carries its own phase counter, which acts as a tapped delay chain: the pulse enters at channel 0 and moves down one tap per step interval. When it leaves the last tap, the column is ready for readout. The step interval, the period and the column count are sampled only while the sequencer is disabled or when a burst is launched into column 0, so a new setting always begins at the start of a rotation. If a column is still occupied when its next start is due, that start is dropped and a sticky overrun flag is set.

Top module: `sample_column_sequencer`

## Requirements
- R1: While `rst_n` is low, every output is zero. After reset, while `enable` is low, `samp_en`, `read_en`, `clr_pulse` and `adc_start` stay zero. Dropping `enable` returns every column to idle on the next edge, and `overrun` keeps its value.
- R2: The sampling enable for column c, channel k is `samp_en[c*9+k]`. A burst launched at edge t holds channel k high for exactly S cycles, from the edge t+k·S on. S is the latched step value. At most one channel of a column is high at any time.
- R3: A period boundary falls in the first cycle with `enable` high and every P cycles after it. P is the latched period. Each boundary launches a burst into columns 0, 1, …, N−1 in turn and then wraps to 0, where N is the latched column count.
- R4: Columns are read in rotation order. At a boundary where the column in turn has finished its burst, `clr_pulse` is high in the following cycle. In the cycle after that, that column's `read_en` bit is high for one cycle and `read_col` holds its index. A column in turn whose burst is still running is waited for. An idle column in turn is passed over.
- R5: `adc_start` is high for one cycle, two cycles after each boundary, so it coincides with any readout that boundary triggers. At most one `read_en` bit is high, and each one is preceded by `clr_pulse`.
- R6: A column's sampling enables are never high while its `read_en` bit is high.
- R7: If the column due for a start is not idle, that start is dropped, the rotation still advances, and `overrun` is set one edge later. `overrun` stays set until reset.
- R8: The step, period and column count are sampled while `enable` is low, and at the boundary that launches column 0, where they already apply to that launch. A change at any other time leaves the bursts and the boundary spacing unchanged until that point.
- R9: A step or period of 0 acts as 1. A column count of 0 acts as 1, and a count above 41 acts as 41.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low aborts all columns |
| cfg_step | input | 16 | Cycles between successive channel enables (T+ΔT) |
| cfg_period | input | 16 | Conversion period in cycles (Ts) |
| cfg_ncols | input | 6 | Number of columns in rotation |
| samp_en | output | 369 | Sampling enables, bit c*9+k for column c channel k |
| read_en | output | 41 | One-hot column readout enable |
| clr_pulse | output | 1 | Integrator clear, one cycle before readout |
| adc_start | output | 1 | Converter start strobe, one per period |
| read_col | output | 6 | Index of the column being read |
| overrun | output | 1 | Sticky flag for a dropped start |

## Verification
A column phase counter that slips by one step moves a channel enable edge at once: the damage shows within a single step interval and again at every later tap of that burst. A wrong rotation or read pointer shows at the next boundary, either as a burst in an unexpected column or as a `read_en`/`read_col` mismatch two cycles after that boundary. A lost or extra busy state shows more slowly, as a false `overrun` or a column restarted too early, one full rotation (N·P cycles) after the fault.

// File: rtl/sample_column_sequencer.sv
module sample_column_sequencer #(
  parameter int NCOL = 41,
  parameter int NCH  = 9,
  parameter int SW   = 16,
  localparam int CIW = $clog2(NCOL + 1),
  localparam int PW  = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [SW-1:0]       cfg_step,
  input  logic [SW-1:0]       cfg_period,
  input  logic [CIW-1:0]      cfg_ncols,
  output logic [NCOL*NCH-1:0] samp_en,
  output logic [NCOL-1:0]     read_en,
  output logic                clr_pulse,
  output logic                adc_start,
  output logic [CIW-1:0]      read_col,
  output logic                overrun
);

  typedef enum logic [2:0] {C_IDLE, C_SAMP, C_DONE, C_CLR, C_READ} cst_t;
  localparam logic [SW-1:0] ONE = SW'(1);

  logic [SW-1:0]  act_step, act_per, pc;
  logic [CIW-1:0] act_n, nxt, rd;
  logic           tick_d;
  logic [NCOL-1:0] busy_v, done_v, clr_v;

  logic [SW-1:0]  step_c, per_c, step_now, per_now;
  logic [CIW-1:0] n_c, n_now, nxt_inc, rd_inc;
  logic tick, at_wrap, start_busy, start_ok, do_read, rd_skip;

  assign step_c = (cfg_step == '0) ? ONE : cfg_step;
  assign per_c  = (cfg_period == '0) ? ONE : cfg_period;
  assign n_c    = (cfg_ncols == '0) ? CIW'(1) :
                  (cfg_ncols > CIW'(NCOL)) ? CIW'(NCOL) : cfg_ncols;

  assign tick     = enable && (pc == '0);
  assign at_wrap  = tick && (nxt == '0);
  assign step_now = at_wrap ? step_c : act_step;
  assign per_now  = at_wrap ? per_c  : act_per;
  assign n_now    = at_wrap ? n_c    : act_n;

  assign start_busy = busy_v[nxt];
  assign start_ok   = tick && !start_busy;
  assign do_read    = tick && done_v[rd];
  assign rd_skip    = tick && !busy_v[rd] && !(start_ok && (nxt == rd));
  assign nxt_inc    = (nxt + CIW'(1) >= n_now) ? '0 : nxt + CIW'(1);
  assign rd_inc     = (rd + CIW'(1) >= n_now) ? '0 : rd + CIW'(1);
  assign clr_pulse  = |clr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_step <= ONE;
      act_per  <= ONE;
      act_n    <= CIW'(1);
      pc       <= '0;
      nxt      <= '0;
      rd       <= '0;
      read_col <= '0;
      overrun  <= 1'b0;
      tick_d   <= 1'b0;
      adc_start <= 1'b0;
    end else if (!enable) begin
      act_step <= step_c;
      act_per  <= per_c;
      act_n    <= n_c;
      pc       <= '0;
      nxt      <= '0;
      rd       <= '0;
      tick_d   <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      pc <= (pc >= per_now - ONE) ? '0 : pc + ONE;
      if (at_wrap) begin
        act_step <= step_c;
        act_per  <= per_c;
        act_n    <= n_c;
      end
      if (tick) nxt <= nxt_inc;
      if (do_read || rd_skip) rd <= rd_inc;
      if (do_read) read_col <= rd;
      if (tick && start_busy) overrun <= 1'b1;
      tick_d    <= tick;
      adc_start <= tick_d;
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    cst_t          st;
    logic [PW-1:0] ph;
    logic [SW-1:0] cnt, stp;
    logic          go, rdgo;

    assign go   = start_ok && (nxt == CIW'(c));
    assign rdgo = do_read && (rd == CIW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= C_IDLE;
        ph  <= '0;
        cnt <= '0;
        stp <= ONE;
      end else if (!enable) begin
        st  <= C_IDLE;
        ph  <= '0;
        cnt <= '0;
      end else begin
        case (st)
          C_IDLE: if (go) begin
            st  <= C_SAMP;
            ph  <= '0;
            cnt <= '0;
            stp <= step_now;
          end
          C_SAMP: if (cnt == stp - ONE) begin
            cnt <= '0;
            if (ph == PW'(NCH - 1)) st <= C_DONE;
            else ph <= ph + PW'(1);
          end else begin
            cnt <= cnt + ONE;
          end
          C_DONE: if (rdgo) st <= C_CLR;
          C_CLR:  st <= C_READ;
          default: st <= C_IDLE;
        endcase
      end
    end

    assign busy_v[c] = (st != C_IDLE);
    assign done_v[c] = (st == C_DONE);
    assign clr_v[c]  = (st == C_CLR);
    assign read_en[c] = (st == C_READ);
    assign samp_en[c*NCH +: NCH] = (st == C_SAMP) ? (NCH'(1) << ph) : '0;

    AST_SAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(samp_en[c*NCH +: NCH])); // R2
    AST_NO_SAMP_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      read_en[c] |-> (samp_en[c*NCH +: NCH] == '0)); // R6
  end

  AST_READ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(read_en)); // R5
  AST_CLR_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|read_en) |-> $past(clr_pulse)); // R5
  AST_READ_COL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|read_en) |-> read_en[read_col]); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7

endmodule

// File: tb/sample_column_sequencer_tb_top.sv
`timescale 1ns/1ps
module sample_column_sequencer_tb_top;
  localparam int NCOL = 41;
  localparam int NCH  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [15:0] cfg_step = 16'd1;
  logic [15:0] cfg_period = 16'd1;
  logic [5:0]  cfg_ncols = 6'd1;
  logic [NCOL*NCH-1:0] samp_en;
  logic [NCOL-1:0] read_en;
  logic clr_pulse, adc_start, overrun;
  logic [5:0] read_col;

  always #2 clk = ~clk;

  sample_column_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_step(cfg_step), .cfg_period(cfg_period), .cfg_ncols(cfg_ncols),
    .samp_en(samp_en), .read_en(read_en), .clr_pulse(clr_pulse),
    .adc_start(adc_start), .read_col(read_col), .overrun(overrun)
  );

  int ncyc = 0;
  int e0 = 0;
  int ntot = 0;
  int nfail = 0;
  always @(posedge clk) ncyc <= ncyc + 1;

  // n[31:24] chan[23:15] count[14:11] readcol[10:5] clr[4] adc[3]; 511/63 = none
  localparam logic [31:0] VEC [16] = '{
    {8'd0,  9'd0,  4'd1, 6'd63, 1'b0, 1'b0, 3'd0},
    {8'd1,  9'd0,  4'd1, 6'd63, 1'b0, 1'b1, 3'd0},
    {8'd2,  9'd1,  4'd1, 6'd63, 1'b0, 1'b0, 3'd0},
    {8'd9,  9'd4,  4'd1, 6'd63, 1'b0, 1'b0, 3'd0},
    {8'd10, 9'd5,  4'd2, 6'd63, 1'b0, 1'b0, 3'd0},
    {8'd11, 9'd9,  4'd2, 6'd63, 1'b0, 1'b1, 3'd0},
    {8'd17, 9'd8,  4'd2, 6'd63, 1'b0, 1'b0, 3'd0},
    {8'd18, 9'd13, 4'd1, 6'd63, 1'b0, 1'b0, 3'd0},
    {8'd20, 9'd18, 4'd2, 6'd63, 1'b1, 1'b0, 3'd0},
    {8'd21, 9'd18, 4'd2, 6'd0,  1'b0, 1'b1, 3'd0},
    {8'd22, 9'd19, 4'd2, 6'd63, 1'b0, 1'b0, 3'd0},
    {8'd28, 9'd22, 4'd1, 6'd63, 1'b0, 1'b0, 3'd0},
    {8'd30, 9'd0,  4'd2, 6'd63, 1'b1, 1'b0, 3'd0},
    {8'd31, 9'd0,  4'd2, 6'd1,  1'b0, 1'b1, 3'd0},
    {8'd41, 9'd9,  4'd2, 6'd2,  1'b0, 1'b1, 3'd0},
    {8'd51, 9'd18, 4'd2, 6'd0,  1'b0, 1'b1, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    enable = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input int s, input int p, input int n);
    cfg_step = 16'(s);
    cfg_period = 16'(p);
    cfg_ncols = 6'(n);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    e0 = ncyc + 1;
  endtask

  task automatic at(input int n);
    while (ncyc < e0 + n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    ntot++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    @(negedge clk);
    chk(samp_en == '0 && read_en == '0 && !clr_pulse && !adc_start && !overrun && read_col == 0,
        "R1", "outputs in reset", longint'($countones(samp_en)), 0);
    do_reset();
    chk(samp_en == '0 && read_en == '0 && !clr_pulse && !adc_start,
        "R1", "idle after reset", longint'($countones(samp_en)), 0);

    // Main vector walk: step 2, period 10, three columns
    run(2, 10, 3);
    for (int i = 0; i < 16; i++) begin
      int n, ch, cnt, rc;
      logic [NCOL-1:0] exp_rd;
      n  = int'(VEC[i][31:24]);
      ch = int'(VEC[i][23:15]);
      cnt = int'(VEC[i][14:11]);
      rc = int'(VEC[i][10:5]);
      exp_rd = (rc == 63) ? '0 : (NCOL'(1) << rc);
      at(n);
      chk(samp_en[ch] == 1'b1, "R2", $sformatf("channel bit %0d at n=%0d", ch, n), samp_en[ch], 1);
      chk($countones(samp_en) == cnt, "R3", $sformatf("active enables at n=%0d", n),
          $countones(samp_en), cnt);
      chk(read_en == exp_rd, "R4", $sformatf("read_en at n=%0d", n), longint'(read_en), longint'(exp_rd));
      if (rc != 63) chk(read_col == 6'(rc), "R4", $sformatf("read_col at n=%0d", n), read_col, rc);
      chk(clr_pulse == VEC[i][4], "R4", $sformatf("clr at n=%0d", n), clr_pulse, VEC[i][4]);
      chk(adc_start == VEC[i][3], "R5", $sformatf("adc at n=%0d", n), adc_start, VEC[i][3]);
      chk(!overrun, "R7", $sformatf("no overrun at n=%0d", n), overrun, 0);
    end

    // R7 overrun: burst 45 cycles, two columns at period 10
    do_reset();
    run(5, 10, 2);
    at(19);
    chk(!overrun, "R7", "overrun before due start", overrun, 0);
    at(20);
    chk(overrun, "R7", "overrun on busy start", overrun, 1);
    chk(samp_en[NCH-1:0] == 9'h010, "R7", "column 0 burst not restarted", longint'(samp_en[NCH-1:0]), 16);
    at(60);
    chk(overrun, "R7", "overrun sticky", overrun, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(samp_en == '0 && read_en == '0, "R1", "disable aborts columns", longint'($countones(samp_en)), 0);
    chk(overrun, "R1", "overrun kept while disabled", overrun, 1);
    do_reset();
    chk(!overrun, "R1", "overrun cleared by reset", overrun, 0);

    // R9 clamp: step 0, one column via count 0
    run(0, 20, 0);
    at(1);
    chk(samp_en[1] && $countones(samp_en) == 1, "R9", "step 0 acts as 1", longint'(samp_en[1]), 1);
    at(20);
    chk(overrun && clr_pulse, "R9", "single column restart blocked", longint'({overrun, clr_pulse}), 3);
    at(21);
    chk(read_en == NCOL'(1), "R9", "single column read", longint'(read_en), 1);
    at(40);
    chk(samp_en[0] && $countones(samp_en) == 1, "R9", "count 0 acts as 1", $countones(samp_en), 1);

    // R9 clamp: count above 41
    do_reset();
    run(1, 10, 63);
    at(400);
    chk(samp_en[40*NCH] == 1'b1, "R9", "column 40 launched", samp_en[40*NCH], 1);
    at(410);
    chk(samp_en[0] == 1'b1 && $countones(samp_en) == 1, "R9", "wrap to column 0 after 41", $countones(samp_en), 1);
    chk(!overrun, "R3", "no overrun in full rotation", overrun, 0);

    // R8 configuration change mid-rotation
    do_reset();
    run(2, 10, 3);
    at(5);
    cfg_step = 16'd3;
    cfg_period = 16'd12;
    at(13);
    chk(samp_en[NCH+1] == 1'b1, "R8", "column 1 keeps old step", samp_en[NCH+1], 1);
    at(31);
    chk(adc_start, "R8", "old period until wrap", adc_start, 1);
    at(35);
    chk(samp_en[1] == 1'b1, "R8", "new step at column 0", samp_en[1], 1);
    at(36);
    chk(samp_en[2] && !samp_en[1], "R8", "new step tap advance", longint'(samp_en[2:1]), 2);
    at(41);
    chk(!adc_start, "R8", "no strobe at old spacing", adc_start, 0);
    at(43);
    chk(adc_start, "R8", "strobe at new period", adc_start, 1);

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule